// File: doc/BRIEF.md
# Multi-Timer Bank with Latched Stamp

This block is a bank of four counters behind a simple synchronous register port. Three of them are reloading down-counters. Timers one and two are 16 bits wide and timer three is 32 bits wide. Each one has its own load, live-count, control and interrupt-clear register. When a counter runs past zero it raises a sticky interrupt line. It then either reloads from its load register or wraps to all ones, depending on the mode bit. Each counter steps on one of two tick-enable inputs, and a control bit picks which one.

The fourth counter is a 40-bit free-running time stamp with no interrupt. It advances on its own tick-enable input. Reading its low word copies the upper byte into a separate high register at the same clock edge. Software can therefore read low then high and rebuild a coherent 40-bit value, even if the counter carries between the two reads.

Reads have one cycle of latency. Clock generation and bus bridging live outside the block. Software stops a timer by writing its control register with the enable bit low. It then writes a new count to the load register and enables the timer again.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every count, load and control register, the stamp counter, its enable and its latched high byte are zero, and all interrupt lines are low.
- R2: Register groups for timers one, two and three start at 0x00, 0x20 and 0x80. Within a group, load is at +0x0, live count at +0x4, control at +0x8 and interrupt clear at +0xC. The stamp low word is at 0x60 and the stamp high register is at 0x64.
- R3: A write to a load register stores the value and also copies it into the live counter. If a tick arrives in the same cycle, the write wins and that tick is dropped.
- R4: Control bit 7 enables counting, bit 6 selects periodic (reload) mode and bit 3 selects the fast tick. The other bits read back as zero. A disabled timer holds its count.
- R5: An enabled timer decrements only on its selected tick (tick_fast when bit 3 is set, otherwise tick_slow). Pulses on the other tick input have no effect.
- R6: In periodic mode, a tick while the count is zero reloads the count from the load register and sets that timer's interrupt line.
- R7: In free-run mode, a tick while the count is zero wraps the count to all ones and sets the interrupt line.
- R8: The interrupt line stays high until any value is written to that timer's clear register. If an underflow happens in the same cycle as the clear, the line stays set.
- R9: Only the low 16 bits of a write reach timers one and two, and all 32 bits reach timer three. Counts read back zero-extended.
- R10: The stamp counter advances by one per tick_stamp pulse only while bit 8 of the 0x64 register is set, and it never drives an interrupt line.
- R11: A read of 0x60 returns the stamp's low 32 bits and, in the same cycle, copies bits 39:32 into the latched high byte. A read of 0x64 returns that latched byte in bits 7:0 and the enable in bit 8. The latched byte does not follow later carries.
- R12: Read data appears on rdata in the cycle after rd_en and holds until the next read. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Register byte address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, one cycle after rd_en |
| tick_slow | input | 1 | Slow count-rate enable for reloading timers |
| tick_fast | input | 1 | Fast count-rate enable for reloading timers |
| tick_stamp | input | 1 | Count enable for the stamp counter |
| irq | output | 3 | Sticky underflow interrupt, one bit per reloading timer |

## Verification
The bench drives the collisions between a tick and a register write. A load write that coincides with a tick must win, or the count comes out one too low. A clear that meets an underflow must leave the interrupt set, or an event is silently lost. It checks that pulses on the unselected tick do nothing; a design with the rate mux wired the wrong way decrements at the wrong rate. It lets the stamp carry into its upper byte between the low and high reads. A design that reads the live upper byte instead of the latched one returns a high byte one too large.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register offsets inside one reloading-timer group
   localparam int unsigned OFS_LOAD = 'h0;
   localparam int unsigned OFS_VAL  = 'h4;
   localparam int unsigned OFS_CTRL = 'h8;
   localparam int unsigned OFS_CLR  = 'hC;

   // group bases and stamp registers
   localparam int unsigned BASE_T1  = 'h00;
   localparam int unsigned BASE_T2  = 'h20;
   localparam int unsigned BASE_T3  = 'h80;
   localparam int unsigned STAMP_LO = 'h60;
   localparam int unsigned STAMP_HI = 'h64;

   // control field positions
   localparam int unsigned CTL_EN   = 7;
   localparam int unsigned CTL_PER  = 6;
   localparam int unsigned CTL_FAST = 3;
   localparam int unsigned STAMP_EN = 8;

   typedef struct packed {
      logic en;
      logic periodic;
      logic fast;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_reload.sv
module tmr_reload
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick_slow,
   input  logic              tick_fast,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_word,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(BASE + OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(BASE + OFS_VAL);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + OFS_CLR);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
      $error("tmr_reload: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W <= CTL_EN) begin : g_bad_data
      $error("tmr_reload: DATA_W too narrow for control field");
   end

   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cnt_q;
   tmr_ctrl_t        ctrl_q;
   logic             irq_q;

   logic wr_load, wr_ctrl, wr_clr;
   logic tick_sel, step, under;
   logic unused_wbits;

   assign wr_load  = wr_en && (addr == A_LOAD);
   assign wr_ctrl  = wr_en && (addr == A_CTRL);
   assign wr_clr   = wr_en && (addr == A_CLR);
   assign tick_sel = ctrl_q.fast ? tick_fast : tick_slow;
   assign step     = ctrl_q.en && tick_sel && !wr_load;
   assign under    = step && (cnt_q == '0);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_load) begin
            load_q <= wdata[CNT_W-1:0];
            cnt_q  <= wdata[CNT_W-1:0];
         end else if (step) begin
            if (under) cnt_q <= ctrl_q.periodic ? load_q : '1;
            else       cnt_q <= cnt_q - 1'b1;
         end
         if (wr_ctrl) begin
            ctrl_q.en       <= wdata[CTL_EN];
            ctrl_q.periodic <= wdata[CTL_PER];
            ctrl_q.fast     <= wdata[CTL_FAST];
         end
         if (under)       irq_q <= 1'b1;
         else if (wr_clr) irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

   always_comb begin
      rd_hit  = 1'b0;
      rd_word = '0;
      unique case (addr)
         A_LOAD: begin rd_hit = 1'b1; rd_word[CNT_W-1:0] = load_q; end
         A_VAL:  begin rd_hit = 1'b1; rd_word[CNT_W-1:0] = cnt_q;  end
         A_CTRL: begin
            rd_hit = 1'b1;
            rd_word[CTL_EN]   = ctrl_q.en;
            rd_word[CTL_PER]  = ctrl_q.periodic;
            rd_word[CTL_FAST] = ctrl_q.fast;
         end
         A_CLR:  rd_hit = 1'b1;
         default: ;
      endcase
   end

   // R3
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> (cnt_q == $past(wdata[CNT_W-1:0])) && (load_q == cnt_q));

   // R4
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !wr_load) |=> $stable(cnt_q));

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (under && ctrl_q.periodic) |=> (cnt_q == $past(load_q)) && irq_q);

   // R7
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (under && !ctrl_q.periodic) |=> (&cnt_q) && irq_q);

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !wr_clr) |=> irq_q);

   // R6
   rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> ($past(cnt_q) == '0));

endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp
   import tmr_pkg::*;
#(
   parameter int unsigned STAMP_W = 40,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_word
);

   localparam int unsigned HI_W = STAMP_W - DATA_W;
   localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(STAMP_LO);
   localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(STAMP_HI);

   if (STAMP_W <= DATA_W || HI_W > STAMP_EN) begin : g_bad_width
      $error("tmr_stamp: upper part must be 1..STAMP_EN bits");
   end
   if (DATA_W <= STAMP_EN) begin : g_bad_data
      $error("tmr_stamp: DATA_W too narrow for enable bit");
   end

   logic [STAMP_W-1:0] cnt_q;
   logic [HI_W-1:0]    hi_q;
   logic               en_q;
   logic               rd_lo, wr_hi;
   logic               unused_wbits;

   assign rd_lo = rd_en && (addr == A_LO);
   assign wr_hi = wr_en && (addr == A_HI);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= '0;
         en_q  <= 1'b0;
      end else begin
         if (en_q && tick) cnt_q <= cnt_q + 1'b1;
         if (rd_lo)        hi_q  <= cnt_q[STAMP_W-1:DATA_W];
         if (wr_hi)        en_q  <= wdata[STAMP_EN];
      end
   end

   always_comb begin
      rd_hit  = 1'b0;
      rd_word = '0;
      if (addr == A_LO) begin
         rd_hit  = 1'b1;
         rd_word = cnt_q[DATA_W-1:0];
      end else if (addr == A_HI) begin
         rd_hit = 1'b1;
         rd_word[HI_W-1:0] = hi_q;
         rd_word[STAMP_EN] = en_q;
      end
   end

   // R11
   snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> (hi_q == $past(cnt_q[STAMP_W-1:DATA_W])));

   // R11
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(hi_q));

   // R10
   stamp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(cnt_q));

   // R10
   stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned T1_W    = 16,
   parameter int unsigned T2_W    = 16,
   parameter int unsigned T3_W    = 32,
   parameter int unsigned STAMP_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick_slow,
   input  logic              tick_fast,
   input  logic              tick_stamp,
   output logic [2:0]        irq
);

   localparam int unsigned NUM_RL = 3;
   localparam int unsigned RL_W    [NUM_RL] = '{T1_W, T2_W, T3_W};
   localparam int unsigned RL_BASE [NUM_RL] = '{BASE_T1, BASE_T2, BASE_T3};

   if (ADDR_W < 8) begin : g_bad_addr
      $error("tmr_bank: ADDR_W must cover the 0x8C register");
   end

   logic [DATA_W-1:0] rl_word [NUM_RL];
   logic [NUM_RL-1:0] rl_hit;
   logic [DATA_W-1:0] st_word;
   logic              st_hit;
   logic [DATA_W-1:0] rd_next;

   for (genvar g = 0; g < NUM_RL; g++) begin : g_rl
      tmr_reload #(
         .CNT_W  (RL_W[g]),
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W),
         .BASE   (RL_BASE[g])
      ) u_rl (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .addr      (addr),
         .wdata     (wdata),
         .tick_slow (tick_slow),
         .tick_fast (tick_fast),
         .rd_hit    (rl_hit[g]),
         .rd_word   (rl_word[g]),
         .irq       (irq[g])
      );
   end

   tmr_stamp #(
      .STAMP_W (STAMP_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_stamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .tick    (tick_stamp),
      .rd_hit  (st_hit),
      .rd_word (st_word)
   );

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NUM_RL; i++) begin
         if (rl_hit[i]) rd_next = rd_next | rl_word[i];
      end
      if (st_hit) rd_next = rd_next | st_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   // R2
   one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rl_hit, st_hit}));

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;

   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_stamp = 1'b0;
   logic [2:0]  irq;

   // narrow second instance so the stamp carries into its upper byte quickly
   logic        wr1 = 1'b0, rd1 = 1'b0;
   logic [7:0]  addr1 = '0;
   logic [15:0] wdata1 = '0;
   logic [15:0] rdata1;
   logic        tick1 = 1'b0;
   logic [2:0]  irq1;

   logic [23:0] m1 = '0;
   logic        m1_en = 1'b0;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tmr_bank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_slow(tick_slow), .tick_fast(tick_fast),
      .tick_stamp(tick_stamp), .irq(irq)
   );

   tmr_bank #(.DATA_W(16), .T3_W(16), .STAMP_W(24)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr1), .rd_en(rd1), .addr(addr1),
      .wdata(wdata1), .rdata(rdata1), .tick_slow(1'b0), .tick_fast(1'b0),
      .tick_stamp(tick1), .irq(irq1)
   );

   // requirement-level model of the narrow stamp (R10)
   always @(posedge clk) begin
      if (!rst_n) begin
         m1 <= '0; m1_en <= 1'b0;
      end else begin
         if (m1_en && tick1) m1 <= m1 + 1'b1;
         if (wr1 && addr1 == 8'h64) m1_en <= wdata1[8];
      end
   end

   task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic pulse(input logic f, input logic s, input logic st, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_fast = f; tick_slow = s; tick_stamp = st;
      end
      @(negedge clk); tick_fast = 1'b0; tick_slow = 1'b0; tick_stamp = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_rd(8'h04, d); chk("R1 t1 value", d, 0);
      bus_rd(8'h08, d); chk("R1 t1 ctrl", d, 0);
      bus_rd(8'h84, d); chk("R1 t3 value", d, 0);
      bus_rd(8'h60, d); chk("R1 stamp low", d, 0);
      bus_rd(8'h64, d); chk("R1 stamp high", d, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_load();
      logic [31:0] d;
      bus_wr(8'h00, 32'h0003_0005);
      bus_rd(8'h04, d); chk("R3 R9 load copies to count", d, 32'h5);
      bus_rd(8'h00, d); chk("R2 load readback", d, 32'h5);
      bus_rd(8'h10, d); chk("R12 unmapped reads zero", d, 0);
   endtask

   task automatic t_rate();
      logic [31:0] d;
      bus_wr(8'h08, 32'hFF);
      bus_rd(8'h08, d); chk("R4 ctrl field readback", d, 32'hC8);
      pulse(1'b0, 1'b1, 1'b0, 4);
      bus_rd(8'h04, d); chk("R5 slow tick ignored in fast mode", d, 32'h5);
      pulse(1'b1, 1'b0, 1'b0, 3);
      bus_rd(8'h04, d); chk("R5 fast ticks count", d, 32'h2);
   endtask

   task automatic t_periodic();
      logic [31:0] d;
      pulse(1'b1, 1'b0, 1'b0, 2);
      bus_rd(8'h04, d); chk("R6 reaches zero", d, 0);
      chk("R6 no irq at zero", irq, 0);
      pulse(1'b1, 1'b0, 1'b0, 1);
      bus_rd(8'h04, d); chk("R6 periodic reload", d, 32'h5);
      chk("R6 irq set", irq, 3'b001);
      pulse(1'b1, 1'b0, 1'b0, 2);
      chk("R8 irq sticky", irq, 3'b001);
      bus_wr(8'h0C, 32'hDEAD);
      chk("R8 clear by any write", irq, 0);
   endtask

   task automatic t_races();
      logic [31:0] d;
      pulse(1'b1, 1'b0, 1'b0, 3);
      @(negedge clk); wr_en = 1'b1; addr = 8'h0C; wdata = 0; tick_fast = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick_fast = 1'b0;
      chk("R8 underflow beats clear", irq, 3'b001);
      bus_rd(8'h04, d); chk("R6 reload during clear", d, 32'h5);
      bus_wr(8'h0C, 0);
      @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 9; tick_fast = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick_fast = 1'b0;
      bus_rd(8'h04, d); chk("R3 load wins over tick", d, 32'h9);
      bus_wr(8'h08, 0);
   endtask

   task automatic t_freerun();
      logic [31:0] d;
      bus_wr(8'h20, 1);
      bus_wr(8'h28, 32'h80);
      pulse(1'b1, 1'b0, 1'b0, 3);
      bus_rd(8'h24, d); chk("R5 fast tick ignored in slow mode", d, 1);
      pulse(1'b0, 1'b1, 1'b0, 2);
      bus_rd(8'h24, d); chk("R7 free-run wraps to ones", d, 32'hFFFF);
      chk("R7 irq set", irq, 3'b010);
      bus_wr(8'h28, 0);
      pulse(1'b0, 1'b1, 1'b0, 5);
      bus_rd(8'h24, d); chk("R4 disabled holds", d, 32'hFFFF);
      bus_wr(8'h2C, 0);
   endtask

   task automatic t_wide();
      logic [31:0] d;
      bus_wr(8'h80, 32'h0001_0000);
      bus_wr(8'h88, 32'hC8);
      pulse(1'b1, 1'b0, 1'b0, 1);
      bus_rd(8'h84, d); chk("R9 t3 32-bit borrow", d, 32'h0000_FFFF);
      bus_wr(8'h80, 0);
      pulse(1'b1, 1'b0, 1'b0, 1);
      chk("R6 t3 irq", irq, 3'b100);
      bus_wr(8'h88, 0);
      bus_wr(8'h8C, 0);
      chk("R8 t3 clear", irq, 0);
   endtask

   task automatic t_stamp();
      logic [31:0] d;
      pulse(1'b0, 1'b0, 1'b1, 4);
      bus_rd(8'h60, d); chk("R10 stamp idle when disabled", d, 0);
      bus_wr(8'h64, 32'h100);
      pulse(1'b0, 1'b0, 1'b1, 6);
      bus_rd(8'h60, d); chk("R10 stamp counts ticks", d, 6);
      bus_rd(8'h64, d); chk("R11 high reg with enable", d, 32'h100);
      chk("R10 stamp raises no irq", irq, 0);
   endtask

   task automatic t_snap();
      logic [23:0] snap;
      @(negedge clk); tick1 = 1'b1; wr1 = 1'b1; addr1 = 8'h64; wdata1 = 16'h100;
      @(negedge clk); wr1 = 1'b0;
      while (m1 < 24'h00FFF0) @(negedge clk);
      rd1 = 1'b1; addr1 = 8'h60; snap = m1;
      @(negedge clk); rd1 = 1'b0;
      chk("R11 low word", rdata1, snap[15:0]);
      repeat (40) @(negedge clk);
      rd1 = 1'b1; addr1 = 8'h64;
      @(negedge clk); rd1 = 1'b0;
      chk("R11 latched byte ignores carry", rdata1, {8'h01, snap[23:16]});
      rd1 = 1'b1; addr1 = 8'h60; snap = m1;
      @(negedge clk); rd1 = 1'b0;
      chk("R11 second low word", rdata1, snap[15:0]);
      rd1 = 1'b1; addr1 = 8'h64;
      @(negedge clk); rd1 = 1'b0;
      chk("R11 relatched byte", rdata1, {8'h01, snap[23:16]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_rate();
      t_periodic();
      t_races();
      t_freerun();
      t_wide();
      t_stamp();
      t_snap();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule